// File: doc/BRIEF.md
# Fast-Stepping Multiplexer Channel Driver

This block is the master side of a three-wire link to an external eight-position serial switch register. Instead of writing a full word for every channel change, it pushes a single marker bit into the register and closes a chip-select frame around every serial clock pulse. Each frame shifts the marker one position further and latches the register, so the enabled switch, and with it the selected multiplexer channel, moves on by one position per clock pulse.

Two selection modes are supported. In single-ended mode one marker travels from position 7 down to position 0, and a new marker is injected every eight pulses. In paired mode a marker is injected every four pulses. Once the first eight pulses have been sent, the register holds two markers four places apart, which enables the pairs 7/3, 6/2, 5/1 and 4/0 in turn. A level input keeps the stepping running. The mode and the clock divider are captured when a run begins. A channel index output reports the position that the last latch enabled.

Top module: `mux_stepper`

## Requirements
- R1: After reset and while no run is active, the serial clock is low, chip-select is high, the data line is low and the channel index is 0.
- R2: Each serial clock high phase lasts div+1 system clock cycles, where div is the divider captured at the start of the run.
- R3: Each frame pulls chip-select low LEAD cycles before the single serial clock rise and keeps it low for LAG cycles after the fall. Between two frames of one run, chip-select then stays high for div+1 cycles.
- R4: The data line changes only while chip-select is high, and it is low whenever chip-select is high.
- R5: In single-ended mode (mode input 0), the data bit of step k (counting from 0 at run start) is 1 exactly when k mod 8 = 0. The external register shifts each bit in at position 7 toward position 0, so after step k it holds only bit 7-(k mod 8).
- R6: In single-ended mode the channel index, updated on each chip-select rise, reads 7-(k mod 8): it counts 7 down to 0 and then wraps back to 7.
- R7: In paired mode (mode input 1), the data bit of step k is 1 exactly when k mod 4 = 0. After step k the register holds bit 7-(k mod 4), and from step 4 onward it also holds bit 3-(k mod 4).
- R8: In paired mode the channel index reads 3-(k mod 4) after each latch, which names the lower switch of the enabled pair.
- R9: Changes to the mode and divider inputs during a run have no effect until the next run starts.
- R10: When the run input falls, the frame in progress completes with its latch, and no further frame starts. A new run restarts the sequence at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Keep stepping while high |
| mode_i | input | 1 | 0 single-ended, 1 paired; captured at run start |
| div_i | input | DIV_W | Serial clock half period minus one, in system cycles |
| sclk_o | output | 1 | Serial clock, idle low |
| din_o | output | 1 | Serial data, to be sampled on the rising serial clock |
| cs_n_o | output | 1 | Active-low chip-select; its rise latches the switches |
| chan_o | output | CNT_W | Channel index enabled by the last latch |

## Verification
The two functions that can coincide are the end of a run and the latch of the frame in progress. The bench drops the run input while chip-select is low in the middle of a paired-mode frame. It then checks that exactly one more latch arrives, with the correct channel and register contents, and that the lines return to idle. A second collision is a change of mode and divider in the same cycles as an active frame. That case is judged by the timing and marker checks, which keep their expected values from the run start.

// File: rtl/mux_step_pkg.sv
package mux_step_pkg;

  typedef enum logic { MODE_SINGLE = 1'b0, MODE_PAIR = 1'b1 } sel_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LEAD = 3'd1,
    PH_HIGH = 3'd2,
    PH_LAG  = 3'd3,
    PH_GAP  = 3'd4
  } phase_e;

  // Marker injection period: the full register, or half of it for pairs.
  function automatic int unsigned period_fn(input sel_mode_e m, input int unsigned nb);
    return (m == MODE_PAIR) ? nb / 2 : nb;
  endfunction

  // Data bit for step k of a run.
  function automatic logic marker_fn(input sel_mode_e m, input int unsigned k,
                                     input int unsigned nb);
    return (k % period_fn(m, nb)) == 0;
  endfunction

  // Channel enabled once step k has been latched.
  function automatic int unsigned chan_fn(input sel_mode_e m, input int unsigned k,
                                          input int unsigned nb);
    int unsigned per;
    per = period_fn(m, nb);
    return per - 1 - (k % per);
  endfunction

endpackage

// File: rtl/mstep_timer.sv
module mstep_timer
  import mux_step_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int LEAD_CYC = 2,
  parameter int LAG_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             start_ev,
  output logic             latch_ev,
  output logic             frame_nxt,
  output logic             sclk_o,
  output logic             cs_n_o
);

  localparam int TMR_W = (DIV_W > 8) ? DIV_W : 8;

  phase_e           ph, ph_nxt;
  logic [TMR_W-1:0] tmr, tmr_nxt;
  logic [DIV_W-1:0] div_q;

  always_comb begin
    ph_nxt   = ph;
    tmr_nxt  = tmr - 1'b1;
    start_ev = 1'b0;
    latch_ev = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        tmr_nxt = '0;
        if (run_i) begin
          ph_nxt   = PH_LEAD;
          tmr_nxt  = TMR_W'(LEAD_CYC - 1);
          start_ev = 1'b1;
        end
      end
      PH_LEAD: if (tmr == '0) begin
        ph_nxt  = PH_HIGH;
        tmr_nxt = TMR_W'(div_q);
      end
      PH_HIGH: if (tmr == '0) begin
        ph_nxt  = PH_LAG;
        tmr_nxt = TMR_W'(LAG_CYC - 1);
      end
      PH_LAG: if (tmr == '0) begin
        ph_nxt   = PH_GAP;
        tmr_nxt  = TMR_W'(div_q);
        latch_ev = 1'b1;
      end
      PH_GAP: if (tmr == '0) begin
        if (run_i) begin
          ph_nxt  = PH_LEAD;
          tmr_nxt = TMR_W'(LEAD_CYC - 1);
        end else begin
          ph_nxt  = PH_IDLE;
          tmr_nxt = '0;
        end
      end
      default: begin
        ph_nxt  = PH_IDLE;
        tmr_nxt = '0;
      end
    endcase
  end

  assign frame_nxt = (ph_nxt == PH_LEAD) || (ph_nxt == PH_HIGH) || (ph_nxt == PH_LAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      tmr    <= '0;
      div_q  <= '0;
      sclk_o <= 1'b0;
      cs_n_o <= 1'b1;
    end else begin
      ph     <= ph_nxt;
      tmr    <= tmr_nxt;
      sclk_o <= (ph_nxt == PH_HIGH);
      cs_n_o <= !frame_nxt;
      if (start_ev) div_q <= div_i;
    end
  end

  // R1: the clock never pulses outside a frame
  a_r1_clock_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);
  // R3: the clock rises only inside an open frame, with chip-select already low
  a_r3_rise_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (!cs_n_o && $past(!cs_n_o)));

endmodule

// File: rtl/mstep_pattern.sv
module mstep_pattern
  import mux_step_pkg::*;
#(
  parameter int REG_BITS = 8,
  parameter int CNT_W    = $clog2(REG_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ev,
  input  logic             latch_ev,
  input  logic             frame_nxt,
  input  logic             mode_i,
  output logic             din_o,
  output logic [CNT_W-1:0] chan_o,
  output logic             mode_q_o
);

  sel_mode_e        mode_q, mode_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    mode_nxt = start_ev ? sel_mode_e'(mode_i) : mode_q;
    if (start_ev)      cnt_nxt = '0;
    else if (latch_ev) cnt_nxt = cnt + 1'b1;
    else               cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SINGLE;
      cnt    <= '0;
      din_o  <= 1'b0;
      chan_o <= '0;
    end else begin
      mode_q <= mode_nxt;
      cnt    <= cnt_nxt;
      din_o  <= frame_nxt && marker_fn(mode_nxt, int'(cnt_nxt), REG_BITS);
      if (latch_ev) chan_o <= CNT_W'(chan_fn(mode_q, int'(cnt), REG_BITS));
    end
  end

  assign mode_q_o = mode_q;

endmodule

// File: rtl/mux_stepper.sv
module mux_stepper
  import mux_step_pkg::*;
#(
  parameter int REG_BITS = 8,
  parameter int DIV_W    = 8,
  parameter int LEAD_CYC = 2,
  parameter int LAG_CYC  = 1,
  parameter int CNT_W    = $clog2(REG_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             mode_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             din_o,
  output logic             cs_n_o,
  output logic [CNT_W-1:0] chan_o
);

  localparam int HALF = REG_BITS / 2;

  logic start_ev;
  logic latch_ev;
  logic frame_nxt;
  logic mode_q;

  mstep_timer #(
    .DIV_W(DIV_W), .LEAD_CYC(LEAD_CYC), .LAG_CYC(LAG_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .div_i(div_i),
    .start_ev(start_ev), .latch_ev(latch_ev), .frame_nxt(frame_nxt),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o)
  );

  mstep_pattern #(
    .REG_BITS(REG_BITS), .CNT_W(CNT_W)
  ) u_pattern (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .latch_ev(latch_ev),
    .frame_nxt(frame_nxt), .mode_i(mode_i),
    .din_o(din_o), .chan_o(chan_o), .mode_q_o(mode_q)
  );

  // R4: data is quiet between frames and steady inside one
  a_r4_din_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !din_o);
  a_r4_din_steady_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o)) |-> $stable(din_o));
  // R6: the index moves only together with a chip-select rise
  a_r6_chan_moves_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cs_n_o) |-> $stable(chan_o));
  // R8: a paired-mode latch names a lower-half channel
  a_r8_pair_channel_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && mode_q) |-> (int'(chan_o) < HALF));

endmodule

// File: tb/sim_mux_stepper.sv
module sim_mux_stepper;

  localparam int LEAD_T = 2;
  localparam int LAG_T  = 1;
  // {mode, div[2:0], steps[4:0]}
  localparam logic [8:0] VEC [5] = '{
    {1'b0, 3'd0, 5'd10},
    {1'b0, 3'd2, 5'd17},
    {1'b1, 3'd1, 5'd11},
    {1'b1, 3'd0, 5'd6},
    {1'b0, 3'd3, 5'd3}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       mode_in = 1'b0;
  logic [7:0] div_in = '0;
  logic       sclk, din, cs_n;
  logic [2:0] chan;

  int  n_chk = 0, n_bad = 0;
  bit  mon_en = 1'b0;
  bit  exp_mode = 1'b0;
  int  exp_div = 0;
  int  k = 0;
  logic [7:0] sw_reg = '0;

  always #2.5 clk = ~clk;

  mux_stepper #(.REG_BITS(8), .DIV_W(8), .LEAD_CYC(LEAD_T), .LAG_CYC(LAG_T)) u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .mode_i(mode_in), .div_i(div_in),
    .sclk_o(sclk), .din_o(din), .cs_n_o(cs_n), .chan_o(chan)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [7:0] exp_reg(input bit m, input int kk);
    logic [7:0] r = '0;
    if (!m) r[7 - kk % 8] = 1'b1;
    else begin
      r[7 - kk % 4] = 1'b1;
      if (kk >= 4) r[3 - kk % 4] = 1'b1;
    end
    return r;
  endfunction

  function automatic int exp_chan(input bit m, input int kk);
    return m ? 3 - kk % 4 : 7 - kk % 8;
  endfunction

  function automatic bit exp_mark(input bit m, input int kk);
    return m ? (kk % 4 == 0) : (kk % 8 == 0);
  endfunction

  // Monitor: models the external switch register and measures timing.
  logic p_sclk = 1'b0, p_cs = 1'b1, p_din = 1'b0;
  int hi_cnt = 0, lead_cnt = 0, lag_cnt = 0, gap_cnt = 0;
  bit seen_rise = 1'b0;
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (p_cs && !cs_n) begin
        if (k > 0) chk(gap_cnt == exp_div + 1, "R3 gap", gap_cnt, exp_div + 1);
        lead_cnt = 1; seen_rise = 1'b0;
      end else if (!cs_n && !sclk && !seen_rise) lead_cnt++;
      if (!p_sclk && sclk) begin
        chk(lead_cnt == LEAD_T, "R3 lead", lead_cnt, LEAD_T);
        chk(din == exp_mark(exp_mode, k), exp_mode ? "R7 marker" : "R5 marker",
            int'(din), int'(exp_mark(exp_mode, k)));
        sw_reg = {din, sw_reg[7:1]};
        seen_rise = 1'b1; hi_cnt = 0;
      end
      if (sclk) hi_cnt++;
      if (p_sclk && !sclk) begin
        chk(hi_cnt == exp_div + 1, "R2 high", hi_cnt, exp_div + 1);
        lag_cnt = 0;
      end
      if (!cs_n && !sclk && seen_rise) lag_cnt++;
      if (!cs_n && p_cs == 1'b0 && din != p_din)
        chk(1'b0, "R4 din moved in frame", int'(din), int'(p_din));
      if (cs_n) chk(!din, "R4 din low deselected", int'(din), 0);
      if (!p_cs && cs_n) begin
        chk(lag_cnt == LAG_T, "R3 lag", lag_cnt, LAG_T);
        chk(sw_reg == exp_reg(exp_mode, k), exp_mode ? "R7 register" : "R5 register",
            int'(sw_reg), int'(exp_reg(exp_mode, k)));
        chk(int'(chan) == exp_chan(exp_mode, k), exp_mode ? "R8 chan" : "R6 chan",
            int'(chan), exp_chan(exp_mode, k));
        k++;
        gap_cnt = 0;
      end
      if (cs_n) gap_cnt++;
    end
    p_sclk = sclk; p_cs = cs_n; p_din = din;
  end

  task automatic wait_steps(input int n);
    while (k < n) begin @(negedge clk); #1; end
  endtask

  task automatic start_run(input bit m, input int d);
    exp_mode = m; exp_div = d; k = 0; sw_reg = '0;
    mode_in = m; div_in = 8'(d);
    run = 1'b1;
  endtask

  task automatic check_idle(input string req);
    repeat (3 * exp_div + 12) @(negedge clk);
    #1;
    chk(cs_n && !sclk && !din, req, int'({cs_n, sclk, din}), 4);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n && !sclk && !din, "R1 reset lines", int'({cs_n, sclk, din}), 4);
    chk(chan == 3'd0, "R1 reset chan", int'(chan), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(cs_n && !sclk && !din, "R1 idle lines", int'({cs_n, sclk, din}), 4);
    mon_en = 1'b1;

    // table of runs
    for (int i = 0; i < 5; i++) begin
      start_run(VEC[i][8], int'(VEC[i][7:5]));
      wait_steps(int'(VEC[i][4:0]));
      run = 1'b0;
      check_idle("R10 idle after run");
      chk(k == int'(VEC[i][4:0]), "R10 step count", k, int'(VEC[i][4:0]));
    end

    // R9: inputs changed mid-run are ignored
    start_run(1'b0, 1);
    wait_steps(2);
    mode_in = 1'b1; div_in = 8'd5;
    wait_steps(10);
    run = 1'b0;
    check_idle("R9 idle");
    chk(k == 10, "R9 step count", k, 10);

    // R10: drop run in the middle of a paired frame
    start_run(1'b1, 0);
    wait_steps(3);
    while (cs_n) begin @(negedge clk); #1; end
    run = 1'b0;
    check_idle("R10 mid-frame stop");
    chk(k == 4, "R10 frame completed", k, 4);

    // R10: restart begins at step 0 (monitor expects channel 7 first)
    start_run(1'b0, 0);
    wait_steps(1);
    chk(int'(chan) == 7, "R10 restart chan", int'(chan), 7);
    wait_steps(3);

    // R1: reset in the middle of a run
    mon_en = 1'b0;
    @(negedge clk); #1;
    rst_n = 1'b0;
    #1;
    chk(cs_n && !sclk && !din, "R1 reset mid-run", int'({cs_n, sclk, din}), 4);
    chk(chan == 3'd0, "R1 reset chan mid-run", int'(chan), 0);
    run = 1'b0;
    finish_run();
  end

endmodule